// File: doc/BRIEF.md
# Deep Standby Power-Down Sequencer

This block controls how a processor subsystem enters and leaves a deep, mostly unpowered standby state. Software first programs a set of small byte-wide registers: standby control, the retention bank selection, a retention key, the wake-pin enables and a wake flag register. It then raises a sleep request strobe. If deep standby is armed, the sequencer runs a fixed series of steps. It freezes the external pin levels, stops the subsystem clock and removes power from the main domain. Retention RAM banks stay supplied only when the key is valid.

During deep standby, a slow always-on tick drives a two-stage synchronizer with an edge compare on each external interrupt pin. An edge on an enabled pin, in an edge-type detection mode, records that pin in the wake flags. It also starts the exit series: power comes back first, then the clock, then the pins are released. On wake, the configuration registers return to their reset values and the wake flags are kept.

Top module: `deep_standby_ctrl`

## Requirements
- R1: A sleep request starts entry only when, in that cycle, the control register at address 0 holds bit0 (standby enable) = 1 and bit1 (deep select) = 1. Otherwise the request is ignored. A register write in the same cycle as the request does not count; its value applies from the next cycle.
- R2: Entry takes one clock per step. `pin_hold` rises in the cycle after the request. `clk_run` falls one cycle later. `dom_pwr_en` falls one cycle after that. `deep_active` rises one cycle after that.
- R3: While `dom_pwr_en` is 1, `ram_keep` is all ones. While it is 0, `ram_keep` equals the bank select field (address 1, bits 3:0) captured at entry, but only if the key register (address 2) held 0x09 at entry. With any other key, `ram_keep` is all zeros.
- R4: While `pin_hold` is 1, `io_out` holds the value `io_in` had at the entry request and ignores `io_in`. Otherwise `io_out` follows `io_in`.
- R5: Only a pin whose enable bit is set in the wake-select register (address 3, bit i for pin i) can wake the block. It must also be in mode 2'b10 (rising) or 2'b01 (falling), taken from `irq_mode[2i+1:2i]`. Mode 2'b00 (low level) and mode 2'b11 (both edges) never wake.
- R6: A qualifying edge sets the pin's bit in the wake flag register (address 4) and leaves deep standby. With `lp_tick` held high, this happens on the third clock edge after the pin changes.
- R7: Exit takes one clock per step. `dom_pwr_en` returns first, with the clock still gated. `clk_run` returns one cycle later. `pin_hold` drops one cycle after that. `core_reset` is high during the two cycles before the pins are released.
- R8: On wake, the control, bank select, key and wake-select registers return to 0. The wake flags keep their value.
- R9: Writing the wake flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. A hardware set in the same cycle as a software clear wins.
- R10: Register writes appear on `reg_rdata` from the next cycle. Read data returns the fields of the addressed register with unused bits as 0, and addresses above 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_tick | input | 1 | Always-on slow clock enable for wake sampling |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sleep_req | input | 1 | Sleep request strobe |
| irq_pin | input | 4 | External interrupt pins |
| irq_mode | input | 8 | Two-bit detection mode per pin |
| io_in | input | 8 | Pin levels driven by the core |
| io_out | output | 8 | Pin levels driven to the pads |
| pin_hold | output | 1 | Pad level latch enable |
| clk_run | output | 1 | Subsystem clock enable |
| dom_pwr_en | output | 1 | Main power domain enable |
| ram_keep | output | 4 | Per-bank retention supply keep |
| core_reset | output | 1 | Reset of non-retained logic during exit |
| deep_active | output | 1 | High while in deep standby |

## Verification
Embedded assertions check the ordering rules on every cycle. The clock is never gated unless the pins are held, and power is never off while the clock runs. Held pad levels stay fixed, and entry happens only after an armed request. A hardware wake set always lands in the flags, and the configuration is cleared after a wake. Only the directed scenarios can show the behaviours that depend on values: the key-gated bank selection, the rejection of level, both-edge and disabled pins, the exact wake latency, and the same-cycle write and request case.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int NUM_BANKS = 4;

    localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_BANK = 3'd1;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd2;
    localparam logic [ADDR_W-1:0] A_WEN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

    localparam logic [DATA_W-1:0] RETAIN_KEY = 8'h09;

    localparam logic [1:0] MODE_LOW  = 2'b00;
    localparam logic [1:0] MODE_FALL = 2'b01;
    localparam logic [1:0] MODE_RISE = 2'b10;
    localparam logic [1:0] MODE_BOTH = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE, S_PIN_LATCH, S_CLK_GATE, S_PWR_OFF,
        S_DEEP, S_PWR_ON, S_CLK_ON, S_RELEASE
    } seq_state_e;

    typedef struct packed {
        logic                  stby_en;
        logic                  deep_sel;
        logic [NUM_BANKS-1:0]  bank_sel;
        logic [DATA_W-1:0]     key;
    } pd_cfg_t;

    function automatic logic edge_qualifies(input logic [1:0] mode,
                                            input logic rise, input logic fall);
        case (mode)
            MODE_RISE: return rise;
            MODE_FALL: return fall;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/dsb_regs.sv
module dsb_regs
    import dsb_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clear_cfg,
    input  logic [NIRQ-1:0]   wake_set,
    output pd_cfg_t           cfg,
    output logic [NIRQ-1:0]   wake_en,
    output logic [NIRQ-1:0]   wake_flag,
    output logic [DATA_W-1:0] rdata
);
    logic [NIRQ-1:0] flag_nxt;

    // configuration: reset on wake as well as on rst
    always_ff @(posedge clk) begin
        if (rst || clear_cfg) begin
            cfg     <= '0;
            wake_en <= '0;
        end else if (we) begin
            case (addr)
                A_CTL: begin
                    cfg.stby_en  <= wdata[0];
                    cfg.deep_sel <= wdata[1];
                end
                A_BANK:  cfg.bank_sel <= wdata[NUM_BANKS-1:0];
                A_KEY:   cfg.key      <= wdata;
                A_WEN:   wake_en      <= wdata[NIRQ-1:0];
                default: ;
            endcase
        end
    end

    // wake flags: write-0-to-clear, hardware set has priority
    always_comb begin
        flag_nxt = wake_flag;
        if (we && addr == A_FLAG)
            flag_nxt = wake_flag & wdata[NIRQ-1:0];
        flag_nxt = flag_nxt | wake_set;
    end

    always_ff @(posedge clk) begin
        if (rst) wake_flag <= '0;
        else     wake_flag <= flag_nxt;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTL:   rdata[1:0]           = {cfg.deep_sel, cfg.stby_en};
            A_BANK:  rdata[NUM_BANKS-1:0] = cfg.bank_sel;
            A_KEY:   rdata                = cfg.key;
            A_WEN:   rdata[NIRQ-1:0]      = wake_en;
            A_FLAG:  rdata[NIRQ-1:0]      = wake_flag;
            default: rdata                = '0;
        endcase
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (|wake_set) |=> ((wake_flag & $past(wake_set)) == $past(wake_set)));

    p_cfg_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        clear_cfg |=> (cfg == '0 && wake_en == '0));
endmodule

// File: rtl/dsb_wake.sv
module dsb_wake
    import dsb_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_tick,
    input  logic              armed,
    input  logic [NIRQ-1:0]   pins,
    input  logic [2*NIRQ-1:0] modes,
    input  logic [NIRQ-1:0]   en,
    output logic [NIRQ-1:0]   hit
);
    localparam int SYNC_W = 3;

    for (genvar i = 0; i < NIRQ; i++) begin : g_pin
        logic [SYNC_W-1:0] sh;
        logic              rise, fall;

        always_ff @(posedge clk) begin
            if (rst)          sh <= '0;
            else if (lp_tick) sh <= {sh[SYNC_W-2:0], pins[i]};
        end

        assign rise   = sh[1] & ~sh[2];
        assign fall   = ~sh[1] & sh[2];
        assign hit[i] = armed & lp_tick & en[i] &
                        edge_qualifies(modes[2*i +: 2], rise, fall);
    end
endmodule

// File: rtl/dsb_seq.sv
module dsb_seq
    import dsb_pkg::*;
#(
    parameter int IO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep_req,
    input  pd_cfg_t              cfg,
    input  logic                 wake,
    input  logic [IO_W-1:0]      io_in,
    output logic [IO_W-1:0]      io_out,
    output logic                 pin_hold,
    output logic                 clk_run,
    output logic                 dom_pwr_en,
    output logic [NUM_BANKS-1:0] ram_keep,
    output logic                 core_reset,
    output logic                 armed,
    output logic                 clear_cfg
);
    seq_state_e           state;
    logic [IO_W-1:0]      held;
    logic [NUM_BANKS-1:0] keep_q;
    logic                 go_deep;

    assign go_deep = sleep_req && cfg.stby_en && cfg.deep_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            held   <= '0;
            keep_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (go_deep) begin
                    state  <= S_PIN_LATCH;
                    held   <= io_in;
                    keep_q <= (cfg.key == RETAIN_KEY) ? cfg.bank_sel : '0;
                end
                S_PIN_LATCH: state <= S_CLK_GATE;
                S_CLK_GATE:  state <= S_PWR_OFF;
                S_PWR_OFF:   state <= S_DEEP;
                S_DEEP:      if (wake) state <= S_PWR_ON;
                S_PWR_ON:    state <= S_CLK_ON;
                S_CLK_ON:    state <= S_RELEASE;
                S_RELEASE:   state <= S_IDLE;
                default:     state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        pin_hold   = state inside {S_PIN_LATCH, S_CLK_GATE, S_PWR_OFF,
                                   S_DEEP, S_PWR_ON, S_CLK_ON};
        clk_run    = !(state inside {S_CLK_GATE, S_PWR_OFF, S_DEEP, S_PWR_ON});
        dom_pwr_en = !(state inside {S_PWR_OFF, S_DEEP});
        core_reset = state inside {S_PWR_ON, S_CLK_ON};
        armed      = (state == S_DEEP);
        clear_cfg  = (state == S_PWR_ON);
        ram_keep   = dom_pwr_en ? '1 : keep_q;
        io_out     = pin_hold ? held : io_in;
    end

    p_gate_needs_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !clk_run |-> pin_hold);

    p_off_needs_gate_r2: assert property (@(posedge clk) disable iff (rst)
        !dom_pwr_en |-> !clk_run);

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_hold && $past(pin_hold)) |-> $stable(io_out));

    p_entry_armed_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_hold) |-> $past(sleep_req && cfg.stby_en && cfg.deep_sel));
endmodule

// File: rtl/deep_standby_ctrl.sv
module deep_standby_ctrl
    import dsb_pkg::*;
#(
    parameter int NIRQ = 4,
    parameter int IO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lp_tick,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 sleep_req,
    input  logic [NIRQ-1:0]      irq_pin,
    input  logic [2*NIRQ-1:0]    irq_mode,
    input  logic [IO_W-1:0]      io_in,
    output logic [IO_W-1:0]      io_out,
    output logic                 pin_hold,
    output logic                 clk_run,
    output logic                 dom_pwr_en,
    output logic [NUM_BANKS-1:0] ram_keep,
    output logic                 core_reset,
    output logic                 deep_active
);
    pd_cfg_t         cfg;
    logic [NIRQ-1:0] wake_en, wake_flag, hit;
    logic            armed, clear_cfg;

    dsb_regs #(.NIRQ(NIRQ)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .clear_cfg(clear_cfg), .wake_set(hit), .cfg(cfg), .wake_en(wake_en),
        .wake_flag(wake_flag), .rdata(reg_rdata)
    );

    dsb_wake #(.NIRQ(NIRQ)) u_wake (
        .clk(clk), .rst(rst), .lp_tick(lp_tick), .armed(armed), .pins(irq_pin),
        .modes(irq_mode), .en(wake_en), .hit(hit)
    );

    dsb_seq #(.IO_W(IO_W)) u_seq (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .cfg(cfg), .wake(|hit),
        .io_in(io_in), .io_out(io_out), .pin_hold(pin_hold), .clk_run(clk_run),
        .dom_pwr_en(dom_pwr_en), .ram_keep(ram_keep), .core_reset(core_reset),
        .armed(armed), .clear_cfg(clear_cfg)
    );

    assign deep_active = armed;
endmodule

// File: tb/test_deep_standby_ctrl.sv
module test_deep_standby_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lp_tick = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic [3:0] irq_pin = 4'b1000;
    logic [7:0] irq_mode = 8'b01_10_11_00; // pin3 fall, pin2 rise, pin1 both, pin0 low
    logic [7:0] io_in = 8'hA5;
    logic [7:0] io_out;
    logic       pin_hold, clk_run, dom_pwr_en, core_reset, deep_active;
    logic [3:0] ram_keep;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    deep_standby_ctrl i_deep_standby_ctrl (
        .clk(clk), .rst(rst), .lp_tick(lp_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sleep_req(sleep_req), .irq_pin(irq_pin), .irq_mode(irq_mode),
        .io_in(io_in), .io_out(io_out), .pin_hold(pin_hold), .clk_run(clk_run),
        .dom_pwr_en(dom_pwr_en), .ram_keep(ram_keep), .core_reset(core_reset),
        .deep_active(deep_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // outputs as {pin_hold, clk_run, dom_pwr_en, core_reset, deep_active}
    function automatic logic [4:0] ctl();
        return {pin_hold, clk_run, dom_pwr_en, core_reset, deep_active};
    endfunction

    task automatic t_reset();
        chk("R2 reset controls", ctl(), 5'b01100);
        chk("R3 reset ram_keep all ones", ram_keep, 4'hF);
        chk("R4 reset io_out follows io_in", io_out, 8'hA5);
        for (int a = 0; a < 5; a++) rd_chk(a[2:0], 8'h00, "R10 reset readback");
    endtask

    task automatic t_regs();
        wr(3'd0, 8'hFF); rd_chk(3'd0, 8'h03, "R10 ctl readback");
        wr(3'd1, 8'hFA); rd_chk(3'd1, 8'h0A, "R10 bank readback");
        wr(3'd2, 8'h5C); rd_chk(3'd2, 8'h5C, "R10 key readback");
        wr(3'd3, 8'hF6); rd_chk(3'd3, 8'h06, "R10 wake enable readback");
        wr(3'd5, 8'hFF); rd_chk(3'd5, 8'h00, "R10 unused address");
        wr(3'd0, 8'h00);
    endtask

    task automatic t_not_armed();
        wr(3'd0, 8'h01);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        idle(2);
        chk("R1 standby only ignored", ctl(), 5'b01100);
        // same-cycle write and request: old value applies
        @(negedge clk); reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h03; sleep_req = 1'b1;
        @(negedge clk); reg_we = 1'b0; sleep_req = 1'b0;
        chk("R1 same-cycle write not used", pin_hold, 1'b0);
        rd_chk(3'd0, 8'h03, "R1 write visible next cycle");
    endtask

    task automatic t_enter(input logic [3:0] exp_keep, input string tag);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk("R2 step1 pins latched", ctl(), 5'b11100);
        io_in = ~io_in;
        @(negedge clk);
        chk("R2 step2 clock gated", ctl(), 5'b10100);
        @(negedge clk);
        chk("R2 step3 power off", ctl(), 5'b10000);
        chk(tag, ram_keep, exp_keep);
        @(negedge clk);
        chk("R2 step4 deep", ctl(), 5'b10001);
    endtask

    task automatic t_keyed_wake();
        io_in = 8'hA5;
        wr(3'd2, 8'h09); wr(3'd1, 8'h05); wr(3'd3, 8'h07); // pin3 disabled
        t_enter(4'h5, "R3 keyed retention banks");
        chk("R4 io_out held at entry value", io_out, 8'hA5);
        // low-level and both-edge pins must not wake
        @(negedge clk); irq_pin[1] = 1'b1; irq_pin[0] = 1'b1;
        idle(5);
        @(negedge clk); irq_pin[1] = 1'b0; irq_pin[0] = 1'b0;
        idle(5);
        chk("R5 low and both modes no wake", deep_active, 1'b1);
        // disabled falling-edge pin must not wake
        @(negedge clk); irq_pin[3] = 1'b0;
        idle(5);
        chk("R5 disabled pin no wake", deep_active, 1'b1);
        // enabled rising pin wakes on the third edge
        @(negedge clk); irq_pin[2] = 1'b1;
        idle(2);
        chk("R6 still deep before third edge", deep_active, 1'b1);
        @(negedge clk);
        chk("R7 exit power on first", ctl(), 5'b10110);
        rd_chk(3'd4, 8'h04, "R6 flag names rising pin");
        chk("R3 all banks on after power", ram_keep, 4'hF);
        @(negedge clk);
        chk("R7 exit clock on", ctl(), 5'b11110);
        chk("R4 pins still held", io_out, 8'hA5);
        @(negedge clk);
        chk("R7 pins released", ctl(), 5'b01100);
        chk("R4 io_out follows after release", io_out, 8'h5A);
        rd_chk(3'd0, 8'h00, "R8 ctl cleared");
        rd_chk(3'd1, 8'h00, "R8 bank cleared");
        rd_chk(3'd2, 8'h00, "R8 key cleared");
        rd_chk(3'd3, 8'h00, "R8 enable cleared");
        rd_chk(3'd4, 8'h04, "R8 flags kept");
    endtask

    task automatic t_flags_and_nokey();
        wr(3'd4, 8'hFF); rd_chk(3'd4, 8'h04, "R9 write one keeps flag");
        wr(3'd4, 8'hFB); rd_chk(3'd4, 8'h00, "R9 write zero clears flag");
        irq_pin = 4'b1000; idle(4);
        wr(3'd2, 8'h08); wr(3'd1, 8'h0F); wr(3'd3, 8'h08); wr(3'd0, 8'h03);
        t_enter(4'h0, "R3 bad key drops all banks");
        @(negedge clk); irq_pin[3] = 1'b0;
        idle(2);
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00;
        @(negedge clk); reg_we = 1'b0;
        chk("R6 falling pin wakes", deep_active, 1'b0);
        rd_chk(3'd4, 8'h08, "R9 hardware set wins over clear");
        idle(3);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_not_armed();
        t_keyed_wake();
        t_flags_and_nokey();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule